// File: doc/BRIEF.md
# Spectral Subtraction Noise Suppressor

This block cleans a stream of per-bin spectral magnitudes, one bin per beat with a bin index and a start-of-frame flag. At the start of a session it watches a fixed number of frames that are taken to hold only background noise. From these frames it learns a per-bin noise level by accumulating each bin and shifting the sum down. Every later frame has that level removed bin by bin. A bin whose remainder falls below a small scaled copy of the noise level is given that scaled copy as its value, so weak bins keep a faint floor and are never set to zero.

Input and output both use valid/ready handshakes. Order, bin index and frame flag pass through unchanged. During learning the block either emits nothing or, if selected, forwards the raw magnitudes. The floor scale is a 12-bit fraction. It defaults to 41/4096 (about 0.01) and can be replaced at run time. A synchronous restart throws away the learned levels so that a new session can learn them again.

Top module: `ss_noise_suppressor`

## Requirements
- R1: After reset or restart, `est_ready_o` is low. A frame counts as complete when its beat with bin index NUM_BINS-1 leaves the input stage. `est_ready_o` goes high one clock after the 8th learning frame completes and then stays high until the next restart.
- R2: The noise level of each bin is floor(S/8), where S is the sum of that bin's magnitudes over the 8 learning frames.
- R3: With `pass_learn_i` low, learning beats produce no output beat.
- R4: With `pass_learn_i` high, every learning beat is sent out with its magnitude, bin and frame flag unchanged.
- R5: After learning, a bin whose magnitude minus its noise level is at least the floor is output as magnitude minus noise level.
- R6: The floor is floor(noise * beta / 4096). When magnitude minus noise is below the floor, including negative results, the output is the floor.
- R7: With `beta_sel_i` low, beta is 41. With it high, beta is `beta_i` (12 bits, all fractional).
- R8: Output beats keep input order, bin index and frame flag. While `out_valid_o` is high and `out_ready_i` is low, the output holds steady.
- R9: `in_ready_o` is high whenever the output register is empty or being drained and no restart is active, so one beat per clock is sustained when `out_ready_i` stays high.
- R10: `restart_i` is synchronous. It holds `in_ready_o` low in its cycle, drops any beat in the input stage, clears the learned levels and learning count, and the next 8 frames build a fresh estimate that keeps nothing from the old one.
- R11: After reset, `out_valid_o` and `est_ready_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| restart_i | input | 1 | Synchronous session restart |
| pass_learn_i | input | 1 | Forward raw magnitudes during learning |
| beta_sel_i | input | 1 | Use `beta_i` in place of the default floor scale |
| beta_i | input | BETA_W | Run-time floor scale, all fractional bits |
| in_valid_i | input | 1 | Input beat valid |
| in_ready_o | output | 1 | Input beat accepted |
| in_sof_i | input | 1 | First bin of a frame |
| in_bin_i | input | BIN_W | Bin index |
| in_mag_i | input | MAG_W | Bin magnitude |
| out_valid_o | output | 1 | Output beat valid |
| out_ready_i | input | 1 | Downstream accepts output |
| out_sof_o | output | 1 | First bin of a frame |
| out_bin_o | output | BIN_W | Bin index |
| out_mag_o | output | MAG_W | Enhanced magnitude |
| est_ready_o | output | 1 | Noise estimate complete |

## Verification
A corrupt accumulator shows up in the first active frame. The affected bins come out offset by the error divided by eight, or pinned at a wrong floor. A learning counter that is off by one raises `est_ready_o` a frame early or late. It also makes one frame come out as subtracted values when silence or raw values are expected, or the reverse. Broken restart clearing is seen in the first active frame after the second learning phase, where stale levels bias every bin. Handshake faults show up at once as a beat that changes while stalled, or as a lost or repeated beat in the scoreboard order.

// File: rtl/ss_pkg.sv
package ss_pkg;
  typedef enum logic {
    PH_LEARN = 1'b0,
    PH_RUN   = 1'b1
  } ss_phase_e;

  localparam int unsigned SS_BETA_DEFAULT = 41;
endpackage

// File: rtl/ss_frame_ctrl.sv
module ss_frame_ctrl #(
  parameter int unsigned LEARN_LOG2 = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             beat_fire_i,
  input  logic             beat_last_i,
  output ss_pkg::ss_phase_e phase_o
);
  localparam int unsigned LEARN_FRAMES = 1 << LEARN_LOG2;
  localparam int unsigned CNT_W        = LEARN_LOG2 + 1;

  logic [CNT_W-1:0] frame_cnt_q;
  logic             learning;

  assign learning = frame_cnt_q < CNT_W'(LEARN_FRAMES);
  assign phase_o  = learning ? ss_pkg::PH_LEARN : ss_pkg::PH_RUN;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_cnt_q <= '0;
    end else if (restart_i) begin
      frame_cnt_q <= '0;
    end else if (beat_fire_i && beat_last_i && learning) begin
      frame_cnt_q <= frame_cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ss_noise_mem.sv
module ss_noise_mem #(
  parameter int unsigned MAG_W      = 16,
  parameter int unsigned NUM_BINS   = 256,
  parameter int unsigned LEARN_LOG2 = 3,
  localparam int unsigned BIN_W     = (NUM_BINS > 1) ? $clog2(NUM_BINS) : 1,
  localparam int unsigned ACC_W     = MAG_W + LEARN_LOG2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             wr_en_i,
  input  logic [BIN_W-1:0] bin_i,
  input  logic [MAG_W-1:0] mag_i,
  output logic [MAG_W-1:0] est_o
);
  logic [ACC_W-1:0] acc_q [NUM_BINS];

  // one accumulator per bin; mean is taken by dropping the low bits
  for (genvar g = 0; g < NUM_BINS; g++) begin : g_bin
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        acc_q[g] <= '0;
      end else if (clear_i) begin
        acc_q[g] <= '0;
      end else if (wr_en_i && (bin_i == BIN_W'(g))) begin
        acc_q[g] <= acc_q[g] + ACC_W'(mag_i);
      end
    end
  end

  logic [ACC_W-1:0] acc_sel;
  assign acc_sel = acc_q[bin_i];
  assign est_o   = acc_sel[ACC_W-1:LEARN_LOG2];
endmodule

// File: rtl/ss_floor_sub.sv
module ss_floor_sub #(
  parameter int unsigned MAG_W  = 16,
  parameter int unsigned BETA_W = 12
) (
  input  logic [MAG_W-1:0]  mag_i,
  input  logic [MAG_W-1:0]  est_i,
  input  logic [BETA_W-1:0] beta_i,
  output logic [MAG_W-1:0]  floor_o,
  output logic [MAG_W-1:0]  res_o
);
  localparam int unsigned PROD_W = MAG_W + BETA_W;

  logic [PROD_W-1:0]       prod;
  logic signed [MAG_W:0]   diff;
  logic signed [MAG_W:0]   floor_s;
  logic                    below;

  assign prod    = PROD_W'(est_i) * PROD_W'(beta_i);
  assign floor_o = prod[PROD_W-1:BETA_W];
  assign diff    = $signed({1'b0, mag_i}) - $signed({1'b0, est_i});
  assign floor_s = $signed({1'b0, floor_o});
  assign below   = diff < floor_s;
  assign res_o   = below ? floor_o : diff[MAG_W-1:0];
endmodule

// File: rtl/ss_noise_suppressor.sv
module ss_noise_suppressor #(
  parameter int unsigned MAG_W      = 16,
  parameter int unsigned NUM_BINS   = 256,
  parameter int unsigned LEARN_LOG2 = 3,
  parameter int unsigned BETA_W     = 12,
  parameter int unsigned BETA_DEF   = ss_pkg::SS_BETA_DEFAULT,
  localparam int unsigned BIN_W     = (NUM_BINS > 1) ? $clog2(NUM_BINS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic              pass_learn_i,
  input  logic              beta_sel_i,
  input  logic [BETA_W-1:0] beta_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic              in_sof_i,
  input  logic [BIN_W-1:0]  in_bin_i,
  input  logic [MAG_W-1:0]  in_mag_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic              out_sof_o,
  output logic [BIN_W-1:0]  out_bin_o,
  output logic [MAG_W-1:0]  out_mag_o,
  output logic              est_ready_o
);
  localparam logic [BIN_W-1:0] LAST_BIN = BIN_W'(NUM_BINS - 1);

  // input stage
  logic             s1_valid_q;
  logic             s1_sof_q;
  logic [BIN_W-1:0] s1_bin_q;
  logic [MAG_W-1:0] s1_mag_q;

  logic              adv;
  logic              s1_fire;
  logic              s1_emit;
  logic              learning;
  ss_pkg::ss_phase_e phase;
  logic [MAG_W-1:0]  s1_est;
  logic [MAG_W-1:0]  sub_floor;
  logic [MAG_W-1:0]  sub_res;
  logic [BETA_W-1:0] beta_eff;

  assign adv        = !out_valid_o || out_ready_i;
  assign in_ready_o = !restart_i && (!s1_valid_q || adv);
  assign s1_fire    = s1_valid_q && adv && !restart_i;
  assign learning   = (phase == ss_pkg::PH_LEARN);
  assign s1_emit    = !learning || pass_learn_i;
  assign beta_eff   = beta_sel_i ? beta_i : BETA_W'(BETA_DEF);
  assign est_ready_o = !learning;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid_q <= 1'b0;
      s1_sof_q   <= 1'b0;
      s1_bin_q   <= '0;
      s1_mag_q   <= '0;
    end else if (restart_i) begin
      s1_valid_q <= 1'b0;
    end else if (in_ready_o) begin
      s1_valid_q <= in_valid_i;
      if (in_valid_i) begin
        s1_sof_q <= in_sof_i;
        s1_bin_q <= in_bin_i;
        s1_mag_q <= in_mag_i;
      end
    end
  end

  ss_frame_ctrl #(
    .LEARN_LOG2 (LEARN_LOG2)
  ) u_frame_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .restart_i   (restart_i),
    .beat_fire_i (s1_fire),
    .beat_last_i (s1_bin_q == LAST_BIN),
    .phase_o     (phase)
  );

  ss_noise_mem #(
    .MAG_W      (MAG_W),
    .NUM_BINS   (NUM_BINS),
    .LEARN_LOG2 (LEARN_LOG2)
  ) u_noise_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (restart_i),
    .wr_en_i (s1_fire && learning),
    .bin_i   (s1_bin_q),
    .mag_i   (s1_mag_q),
    .est_o   (s1_est)
  );

  ss_floor_sub #(
    .MAG_W  (MAG_W),
    .BETA_W (BETA_W)
  ) u_floor_sub (
    .mag_i   (s1_mag_q),
    .est_i   (s1_est),
    .beta_i  (beta_eff),
    .floor_o (sub_floor),
    .res_o   (sub_res)
  );

  // output register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_sof_o   <= 1'b0;
      out_bin_o   <= '0;
      out_mag_o   <= '0;
    end else if (adv) begin
      out_valid_o <= s1_fire && s1_emit;
      if (s1_fire && s1_emit) begin
        out_sof_o <= s1_sof_q;
        out_bin_o <= s1_bin_q;
        out_mag_o <= learning ? s1_mag_q : sub_res;
      end
    end
  end
endmodule

// File: rtl/ss_noise_suppressor_chk.sv
module ss_noise_suppressor_chk #(
  parameter int unsigned MAG_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             restart_i,
  input logic             pass_learn_i,
  input logic             in_ready_o,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic             out_sof_o,
  input logic [MAG_W-1:0] out_mag_o,
  input logic             est_ready_o,
  input logic             s1_fire_c,
  input logic             learning_c,
  input logic [MAG_W-1:0] floor_c
);
  p_est_start_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !est_ready_o);

  p_est_sticky_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (est_ready_o && !restart_i) |=> est_ready_o);

  p_silent_learn_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_fire_c && learning_c && !pass_learn_i && !restart_i) |=> !out_valid_o);

  p_floor_min_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_fire_c && !learning_c) |=> (out_mag_o >= $past(floor_c)));

  p_out_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(out_mag_o) && $stable(out_sof_o)));

  p_ready_empty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!out_valid_o && !restart_i) |-> in_ready_o);

  p_restart_block_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |-> !in_ready_o);
endmodule

bind ss_noise_suppressor ss_noise_suppressor_chk #(
  .MAG_W (MAG_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .restart_i    (restart_i),
  .pass_learn_i (pass_learn_i),
  .in_ready_o   (in_ready_o),
  .out_valid_o  (out_valid_o),
  .out_ready_i  (out_ready_i),
  .out_sof_o    (out_sof_o),
  .out_mag_o    (out_mag_o),
  .est_ready_o  (est_ready_o),
  .s1_fire_c    (s1_fire),
  .learning_c   (learning),
  .floor_c      (sub_floor)
);

// File: tb/ss_noise_suppressor_tb.sv
module ss_noise_suppressor_tb;
  localparam int NB    = 16;
  localparam int BW    = 4;
  localparam int MW    = 16;
  localparam int BETW  = 12;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            restart_i = 1'b0;
  logic            pass_learn_i = 1'b0;
  logic            beta_sel_i = 1'b0;
  logic [BETW-1:0] beta_i = '0;
  logic            in_valid_i = 1'b0;
  logic            in_ready_o;
  logic            in_sof_i = 1'b0;
  logic [BW-1:0]   in_bin_i = '0;
  logic [MW-1:0]   in_mag_i = '0;
  logic            out_valid_o;
  logic            out_ready_i = 1'b1;
  logic            out_sof_o;
  logic [BW-1:0]   out_bin_o;
  logic [MW-1:0]   out_mag_o;
  logic            est_ready_o;

  always #10 clk_i = ~clk_i;

  ss_noise_suppressor #(.NUM_BINS(NB)) u_dut (
    .clk_i, .rst_ni, .restart_i, .pass_learn_i, .beta_sel_i, .beta_i,
    .in_valid_i, .in_ready_o, .in_sof_i, .in_bin_i, .in_mag_i,
    .out_valid_o, .out_ready_i, .out_sof_o, .out_bin_o, .out_mag_o,
    .est_ready_o
  );

  typedef struct { bit sof; int bin; int mag; string req; } item_t;
  item_t exp_q[$];

  int checks = 0, errors = 0;
  int acc_m [NB];
  int frames_m = 0;
  int stall_mode = 0;
  int out_seen = 0;
  int retries = 0;
  bit done = 0;
  logic [15:0] lfsr = 16'hACE1;
  string cur_req = "R5";

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  function automatic int model_out(input int bin, input int mag);
    int est, beta, flo, diff;
    est  = acc_m[bin] >> 3;
    beta = beta_sel_i ? int'(beta_i) : 41;
    flo  = (est * beta) >> 12;
    diff = mag - est;
    return (diff < flo) ? flo : diff;
  endfunction

  task automatic send_beat(input bit sof, input int bin, input int mag);
    bit acc;
    item_t it;
    in_valid_i = 1'b1; in_sof_i = sof; in_bin_i = BW'(bin); in_mag_i = MW'(mag);
    forever begin
      #2; acc = in_ready_o;
      @(posedge clk_i);
      if (acc) break;
      retries++;
      @(negedge clk_i);
    end
    it.sof = sof; it.bin = bin; it.req = cur_req;
    if (frames_m < 8) begin
      acc_m[bin] += mag;
      if (pass_learn_i) begin it.mag = mag; exp_q.push_back(it); end
      if (bin == NB-1) frames_m++;
    end else begin
      it.mag = model_out(bin, mag);
      exp_q.push_back(it);
    end
    @(negedge clk_i);
    in_valid_i = 1'b0;
  endtask

  // kind: 0 noise A, 1 strong, 2 weak, 3 zero, 4 max, 5 noise B
  function automatic int gen_mag(input int kind, input int bin, input int k);
    case (kind)
      0: return 200 + bin*10 + ((k*7 + bin*3) % 16);
      1: return 3000 + bin*37;
      2: return 205 + bin*10 + (k % 3);
      3: return 0;
      4: return 65535;
      default: return 1000 + bin*50 + ((k*5 + bin) % 8);
    endcase
  endfunction

  task automatic send_frame(input int kind, input int k);
    for (int b = 0; b < NB; b++) send_beat(b == 0, b, gen_mag(kind, b, k));
  endtask

  task automatic drain();
    int t = 0;
    while ((exp_q.size() != 0 || out_valid_o) && t < 2000) begin
      @(negedge clk_i); t++;
    end
    #3;
    chk(exp_q.size() == 0, "R8", exp_q.size(), 0);
  endtask

  // monitor / scoreboard
  bit          prev_stall = 0;
  logic [MW-1:0] prev_mag;
  logic [BW-1:0] prev_bin;
  initial begin
    forever begin
      @(negedge clk_i);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready_i = (stall_mode == 0) ? 1'b1 : lfsr[0];
      #1;
      if (rst_ni && prev_stall) begin
        chk(out_valid_o && out_mag_o == prev_mag && out_bin_o == prev_bin,
            "R8", int'(out_mag_o), int'(prev_mag));
      end
      if (rst_ni && out_valid_o && out_ready_i) begin
        out_seen++;
        if (exp_q.size() == 0) begin
          chk(0, "R3", int'(out_mag_o), -1);
        end else begin
          item_t e;
          e = exp_q.pop_front();
          chk(out_sof_o == e.sof && int'(out_bin_o) == e.bin,
              "R8", int'(out_bin_o), e.bin);
          chk(int'(out_mag_o) == e.mag, e.req, int'(out_mag_o), e.mag);
        end
      end
      prev_stall = rst_ni && out_valid_o && !out_ready_i;
      prev_mag = out_mag_o;
      prev_bin = out_bin_o;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NB; i++) acc_m[i] = 0;
    #5;
    chk(out_valid_o == 0, "R11", out_valid_o, 0);
    chk(est_ready_o == 0, "R11", est_ready_o, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    #2;
    chk(in_ready_o == 1, "R9", in_ready_o, 1);

    // learning, silent (R3, R2)
    cur_req = "R3";
    for (int k = 0; k < 7; k++) send_frame(0, k);
    repeat (4) @(negedge clk_i);
    chk(out_seen == 0, "R3", out_seen, 0);
    chk(est_ready_o == 0, "R1", est_ready_o, 0);
    send_frame(0, 7);
    @(negedge clk_i);
    chk(est_ready_o == 1, "R1", est_ready_o, 1);

    // active frames, no stall: throughput (R9) and subtraction (R5, R2)
    cur_req = "R5";
    retries = 0;
    send_frame(1, 0);
    chk(retries == 0, "R9", retries, 0);
    drain();
    cur_req = "R6";
    send_frame(2, 0);
    send_frame(2, 1);
    send_frame(3, 0);
    cur_req = "R5";
    send_frame(4, 0);
    drain();

    // backpressure (R8)
    stall_mode = 1;
    cur_req = "R8";
    send_frame(1, 1);
    send_frame(2, 2);
    drain();
    stall_mode = 0;

    // beta override (R7)
    cur_req = "R7";
    beta_sel_i = 1'b1; beta_i = 12'd2048;
    send_frame(2, 0);
    send_frame(1, 0);
    drain();
    beta_i = 12'd4095;
    send_frame(2, 1);
    drain();
    beta_sel_i = 1'b0;

    // restart (R10), then learning with pass-through (R4)
    @(negedge clk_i);
    restart_i = 1'b1;
    #2;
    chk(in_ready_o == 0, "R10", in_ready_o, 0);
    @(negedge clk_i);
    restart_i = 1'b0;
    #1;
    chk(est_ready_o == 0, "R10", est_ready_o, 0);
    for (int i = 0; i < NB; i++) acc_m[i] = 0;
    frames_m = 0;
    pass_learn_i = 1'b1;
    cur_req = "R4";
    for (int k = 0; k < 8; k++) send_frame(5, k);
    @(negedge clk_i);
    chk(est_ready_o == 1, "R1", est_ready_o, 1);
    cur_req = "R10";
    send_frame(1, 2);
    send_frame(2, 3);
    drain();
    cur_req = "R2";
    stall_mode = 1;
    send_frame(4, 0);
    drain();

    repeat (3) @(negedge clk_i);
    finish_run();
  end
endmodule